// File: doc/BRIEF.md
# IR Serial Pulse Encoder/Decoder

This block sits between a byte-oriented host path and an infrared transceiver. It runs at a fixed rate of 9600 baud from a 7.3728 MHz clock. A bit cell is split into 16 sub-bit ticks of 48 clocks each, so one cell is 768 clocks long.

On the transmit side the block accepts a byte over a valid/ready handshake and sends a frame of ten cells: a start cell, eight data cells and a stop cell. Every cell that carries a zero, the start cell included, gets one short pulse of 12 clocks (1.63 µs) at its leading edge. Cells that carry a one, and the stop cell, leave the line low.

On the receive side the block takes a detector line that is already thresholded but not yet synchronized. It synchronizes that line and aligns to the rising edge of the start pulse. It then decides each of the eight data cells by whether a pulse edge falls inside the cell. The finished byte is presented with a one-cycle strobe. The receiver does not wait for a stop cell, so frames may follow each other without any gap.

Top module: `ir_pulse_codec`

## Requirements
- R1: After reset `tx_ready_o` is 1, `ir_tx_o` is 0 and `rx_valid_o` is 0.
- R2: A byte is taken on a clock edge where `tx_valid_i` and `tx_ready_o` are both 1. `tx_ready_o` is then 0 for exactly 10 × CLKS_PER_TICK × TICKS_PER_BIT clocks, starting with the next cycle.
- R3: The transmit frame is a start cell (value 0), eight data cells and a stop cell (value 1). A cell of value 0 drives `ir_tx_o` high for exactly PULSE_CLKS clocks from the first clock of the cell, and low for the rest of the cell. A cell of value 1 keeps `ir_tx_o` low for the whole cell.
- R4: Data cells carry the byte least significant bit first, on both transmit and receive.
- R5: While `tx_ready_o` is 0, `tx_valid_i` and `tx_data_i` have no effect on the frame being sent.
- R6: While the receiver is idle, a rising edge on the synchronized `ir_rx_i` starts a frame. A data cell that contains a rising edge decodes as 0, and a data cell without one decodes as 1. The byte appears on `rx_data_o` together with a `rx_valid_o` pulse that is exactly one cycle long.
- R7: The receiver neither times nor checks a stop cell. A new start pulse that arrives right after the eighth data cell is decoded as the next frame.
- R8: The receiver decodes by pulse edges, not by pulse width or exact position. A pulse of any width from 1 clock up to half a cell is accepted. A data pulse that lands up to a quarter cell after the nominal cell start is also accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | DATA_BITS | Byte to send |
| tx_valid_i | input | 1 | Byte on `tx_data_i` is valid |
| tx_ready_o | output | 1 | Encoder is idle and can accept a byte |
| ir_tx_o | output | 1 | Pulse output to the IR emitter |
| ir_rx_i | input | 1 | Thresholded detector input, asynchronous |
| rx_data_o | output | DATA_BITS | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new byte on `rx_data_o` |

## Verification
The bench builds the block with 4 clocks per tick, 16 ticks per bit and a 3-clock pulse. This gives a 64-clock cell, so it can compare full frames clock by clock and exercise many frames within a short run. With these values the pulse is still shorter than one tick, as it is with the defaults. The tick and cell counters still wrap over their full ranges, so the transmit waveform and the receiver's half-cell alignment are covered the same way as at 48 clocks per tick. The ready-low window length is checked against the parameter-derived frame length.

// File: rtl/ir_pulse_codec_pkg.sv
package ir_pulse_codec_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_FRAME = 1'b1
  } rx_state_e;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ir_bit_timer.sv
module ir_bit_timer #(
  parameter int CLKS_PER_TICK = 48,
  parameter int TICKS_PER_BIT = 16,
  localparam int PW = ir_pulse_codec_pkg::cnt_width(CLKS_PER_TICK),
  localparam int TW = ir_pulse_codec_pkg::cnt_width(TICKS_PER_BIT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_tick_i,
  input  logic          run_i,
  output logic [PW-1:0] pre_o,
  output logic [TW-1:0] tick_o,
  output logic          cell_end_o
);
  localparam logic [PW-1:0] PRE_LAST  = PW'(CLKS_PER_TICK - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);

  logic [PW-1:0] pre_q;
  logic [TW-1:0] tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else if (load_i) begin
      pre_q  <= '0;
      tick_q <= load_tick_i;
    end else if (run_i) begin
      if (pre_q == PRE_LAST) begin
        pre_q  <= '0;
        tick_q <= (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign pre_o      = pre_q;
  assign tick_o     = tick_q;
  assign cell_end_o = run_i && (pre_q == PRE_LAST) && (tick_q == TICK_LAST);
endmodule

// File: rtl/ir_pulse_tx.sv
module ir_pulse_tx #(
  parameter int CLKS_PER_TICK = 48,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_CLKS    = 12,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic                 ir_o
);
  localparam int FB = DATA_BITS + 2;
  localparam int CW = ir_pulse_codec_pkg::cnt_width(FB);
  localparam int PW = ir_pulse_codec_pkg::cnt_width(CLKS_PER_TICK);
  localparam int TW = ir_pulse_codec_pkg::cnt_width(TICKS_PER_BIT);
  localparam logic [CW-1:0] CELL_LAST = CW'(FB - 1);

  logic          busy_q;
  logic [FB-1:0] frame_q;
  logic [CW-1:0] cell_q;
  logic [PW-1:0] pre;
  logic [TW-1:0] tick;
  logic          cell_end;
  logic          accept;

  assign accept = valid_i && !busy_q;

  ir_bit_timer #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_tick_i('0),
    .run_i      (busy_q),
    .pre_o      (pre),
    .tick_o     (tick),
    .cell_end_o (cell_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cell_q  <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      frame_q <= {1'b1, data_i, 1'b0};
      cell_q  <= '0;
    end else if (busy_q && cell_end) begin
      frame_q <= {1'b1, frame_q[FB-1:1]};
      if (cell_q == CELL_LAST) busy_q <= 1'b0;
      else                     cell_q <= cell_q + 1'b1;
    end
  end

  // pulse sits in the first tick; PULSE_CLKS must not exceed CLKS_PER_TICK
  assign ir_o    = busy_q && !frame_q[0] && (tick == '0) && (int'(pre) < PULSE_CLKS);
  assign ready_o = !busy_q;
endmodule

// File: rtl/ir_pulse_rx.sv
module ir_pulse_rx #(
  parameter int CLKS_PER_TICK = 48,
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ir_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o
);
  import ir_pulse_codec_pkg::*;

  localparam int CW = cnt_width(DATA_BITS + 1);
  localparam int PW = cnt_width(CLKS_PER_TICK);
  localparam int TW = cnt_width(TICKS_PER_BIT);
  localparam logic [CW-1:0] CELL_LAST = CW'(DATA_BITS);
  // window starts half a cell early so edges land mid-window
  localparam logic [TW-1:0] HALF_TICK = TW'(TICKS_PER_BIT / 2);

  rx_state_e            state_q;
  logic [2:0]           sync_q;
  logic                 rise;
  logic                 seen_q;
  logic [CW-1:0]        cell_q;
  logic [DATA_BITS-1:0] shift_q;
  logic [DATA_BITS-1:0] data_q;
  logic                 valid_q;
  logic                 start;
  logic                 cell_end;
  logic                 bit_val;
  logic [PW-1:0]        pre_unused;
  logic [TW-1:0]        tick_unused;

  assign rise    = sync_q[1] && !sync_q[2];
  assign start   = (state_q == RX_IDLE) && rise;
  assign bit_val = !(seen_q || rise);

  ir_bit_timer #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_tick_i(HALF_TICK),
    .run_i      (state_q == RX_FRAME),
    .pre_o      (pre_unused),
    .tick_o     (tick_unused),
    .cell_end_o (cell_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], ir_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      seen_q  <= 1'b0;
      cell_q  <= '0;
      shift_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        state_q <= RX_FRAME;
        cell_q  <= '0;
        seen_q  <= 1'b0;
      end else if (state_q == RX_FRAME) begin
        if (cell_end) begin
          seen_q <= 1'b0;
          if (cell_q != '0) shift_q <= {bit_val, shift_q[DATA_BITS-1:1]};
          if (cell_q == CELL_LAST) begin
            state_q <= RX_IDLE;
            valid_q <= 1'b1;
            data_q  <= {bit_val, shift_q[DATA_BITS-1:1]};
          end else begin
            cell_q <= cell_q + 1'b1;
          end
        end else begin
          seen_q <= seen_q || rise;
        end
      end
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ir_pulse_codec.sv
module ir_pulse_codec #(
  parameter int CLKS_PER_TICK = 48,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_CLKS    = 12,
  parameter int DATA_BITS     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_BITS-1:0] tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 ir_tx_o,
  input  logic                 ir_rx_i,
  output logic [DATA_BITS-1:0] rx_data_o,
  output logic                 rx_valid_o
);
  ir_pulse_tx #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .PULSE_CLKS   (PULSE_CLKS),
    .DATA_BITS    (DATA_BITS)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (tx_data_i),
    .valid_i(tx_valid_i),
    .ready_o(tx_ready_o),
    .ir_o   (ir_tx_o)
  );

  ir_pulse_rx #(
    .CLKS_PER_TICK(CLKS_PER_TICK),
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_BITS    (DATA_BITS)
  ) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_rx_i),
    .data_o (rx_data_o),
    .valid_o(rx_valid_o)
  );
endmodule

// File: rtl/ir_pulse_codec_chk.sv
module ir_pulse_codec_chk #(
  parameter int CLKS_PER_TICK = 48,
  parameter int TICKS_PER_BIT = 16,
  parameter int PULSE_CLKS    = 12,
  parameter int DATA_BITS     = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic ir_tx_o,
  input logic rx_valid_o
);
  localparam int FRAME_CLKS = (DATA_BITS + 2) * CLKS_PER_TICK * TICKS_PER_BIT;

  int busy_cnt;
  int hi_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_cnt <= 0;
      hi_run   <= 0;
    end else begin
      busy_cnt <= tx_ready_o ? 0 : busy_cnt + 1;
      hi_run   <= ir_tx_o ? hi_run + 1 : 0;
    end
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> !tx_ready_o);

  p_busy_length_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_ready_o) |-> busy_cnt == FRAME_CLKS);

  p_quiet_when_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> !ir_tx_o);

  p_pulse_max_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_tx_o |-> hi_run < PULSE_CLKS);

  p_pulse_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ir_tx_o) |-> hi_run == PULSE_CLKS);

  p_strobe_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
endmodule

bind ir_pulse_codec ir_pulse_codec_chk #(
  .CLKS_PER_TICK(CLKS_PER_TICK),
  .TICKS_PER_BIT(TICKS_PER_BIT),
  .PULSE_CLKS   (PULSE_CLKS),
  .DATA_BITS    (DATA_BITS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o),
  .ir_tx_o   (ir_tx_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/tb_ir_pulse_codec.sv
`timescale 1ns/1ps
module tb_ir_pulse_codec;
  localparam int CPT = 4;
  localparam int TPB = 16;
  localparam int PUL = 3;
  localparam int DB  = 8;
  localparam int B   = CPT * TPB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DB-1:0] tx_data = '0;
  logic          tx_valid = 1'b0;
  logic          tx_ready;
  logic          ir_tx;
  logic          man_ir = 1'b0;
  logic          loop_en = 1'b0;
  logic          ir_in;
  logic [DB-1:0] rx_data;
  logic          rx_valid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rx_cnt = 0;
  int rx_multi = 0;
  logic          rx_prev = 1'b0;
  logic [DB-1:0] rx_hist [0:31];

  assign ir_in = loop_en ? ir_tx : man_ir;

  always #4 clk = ~clk;

  ir_pulse_codec #(
    .CLKS_PER_TICK(CPT), .TICKS_PER_BIT(TPB), .PULSE_CLKS(PUL), .DATA_BITS(DB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .ir_tx_o(ir_tx), .ir_rx_i(ir_in),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && rx_valid) begin
      if (rx_cnt < 32) rx_hist[rx_cnt] = rx_data;
      rx_cnt = rx_cnt + 1;
      if (rx_prev) rx_multi = rx_multi + 1;
    end
    rx_prev = rx_valid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    check(ir_tx == 1'b0, "R1 ir_tx", ir_tx, 0);
    check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
  endtask

  // loopback send: waveform (R3, R4), ready window (R2), busy valid ignored (R5), decode (R6)
  task automatic t_send(input logic [DB-1:0] b);
    int wave_bad = 0;
    int first_bad = -1;
    int rdy_bad = 0;
    int rx0;
    logic [DB+1:0] fr;
    fr = {1'b1, b, 1'b0};
    loop_en = 1'b1;
    rx0 = rx_cnt;
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~b;
    for (int j = 1; j <= 10 * B; j++) begin
      logic exp_ir;
      exp_ir = !fr[(j - 1) / B] && (((j - 1) % B) < PUL);
      if (ir_tx !== exp_ir) begin
        wave_bad++;
        if (first_bad < 0) first_bad = j;
      end
      if (tx_ready !== 1'b0) rdy_bad++;
      if (j == 3 * B) tx_valid = 1'b1;
      if (j == 10 * B - 4) tx_valid = 1'b0;
      @(negedge clk);
    end
    check(wave_bad == 0, "R3/R4/R5 waveform mismatches", wave_bad, 0);
    check(rdy_bad == 0, "R2 ready low window", rdy_bad, 0);
    check(tx_ready == 1'b1, "R2 ready back after frame", tx_ready, 1);
    check(rx_cnt == rx0 + 1, "R6 loopback byte count", rx_cnt - rx0, 1);
    if (rx_cnt > rx0 && rx_cnt <= 32)
      check(rx_hist[rx_cnt-1] == b, "R4/R6 loopback data", rx_hist[rx_cnt-1], b);
    repeat (B) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [DB-1:0] b, input int w, input int dly);
    for (int k = 0; k < DB + 1; k++) begin
      bit z;
      int d;
      z = (k == 0) || !b[k-1];
      d = (k == 0) ? 0 : dly;
      for (int p = 0; p < B; p++) begin
        man_ir = z && (p >= d) && (p < d + w);
        @(negedge clk);
      end
    end
    man_ir = 1'b0;
  endtask

  task automatic t_rx_manual(input logic [DB-1:0] b, input int w, input int dly, input string req);
    int rx0;
    loop_en = 1'b0;
    rx0 = rx_cnt;
    drive_frame(b, w, dly);
    repeat (B) @(negedge clk);
    check(rx_cnt == rx0 + 1, req, rx_cnt - rx0, 1);
    if (rx_cnt > rx0 && rx_cnt <= 32)
      check(rx_hist[rx_cnt-1] == b, req, rx_hist[rx_cnt-1], b);
  endtask

  // R7: second start pulse directly after the eighth data cell
  task automatic t_back_to_back(input logic [DB-1:0] b1, input logic [DB-1:0] b2);
    int rx0;
    loop_en = 1'b0;
    rx0 = rx_cnt;
    drive_frame(b1, PUL, 0);
    drive_frame(b2, PUL, 0);
    repeat (B) @(negedge clk);
    check(rx_cnt == rx0 + 2, "R7 back-to-back count", rx_cnt - rx0, 2);
    if (rx_cnt >= rx0 + 2 && rx_cnt <= 32) begin
      check(rx_hist[rx0] == b1, "R7 first byte", rx_hist[rx0], b1);
      check(rx_hist[rx0+1] == b2, "R7 second byte", rx_hist[rx0+1], b2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send(8'h00);
    t_send(8'hFF);
    t_send(8'hA5);
    t_send(8'h01);
    t_rx_manual(8'h3C, PUL, 0, "R6 direct frame");
    t_rx_manual(8'hFF, PUL, 0, "R6 only start pulse");
    t_rx_manual(8'h5A, 1, 0, "R8 one-clock pulses");
    t_rx_manual(8'hC3, B / 2, 0, "R8 half-cell pulses");
    t_rx_manual(8'h96, PUL, B / 4, "R8 late pulses");
    t_back_to_back(8'h81, 8'h7E);
    check(rx_multi == 0, "R6 strobe length", rx_multi, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule